// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the device last left reset, and of the levels on the configuration strap pins at that reset. Five reset request lines come in as plain levels: loss of clock, loss of PLL lock, watchdog or debug, a software request, and the external reset pin. A sixth line, the power-on request, acts as the block's asynchronous reset. When one or more requests rise while the block is idle, a fixed priority picks a single winner. The winner's cause flag is set and every other cause flag is cleared. The power-on flag is the one flag that does not follow this rule. It survives resets that come from the external pin, and any other source clears it.

The wake-up strap pin and the two boot strap pins are captured in the cycle in which the last active request goes away. They then hold until the next reset, even if the pins change. Software sees everything as one 32-bit read-only word. It pulses the read strobe and takes the word, flagged by a valid pulse, one cycle later. The read port has no back-pressure: the data is always accepted. Bits are numbered from the most significant end, so position 0 is `word[31]`.

Top module: `rst_cause_status`

## Requirements
- R1: While the power-on request is high, and after it is released, the word has `word[31]` (power-on flag) and `word[30]` (external flag) set. The other cause bits `word[29:26]` read 0.
- R2: A reset acknowledged from the external pin sets `word[30]`, clears `word[29:26]`, and leaves `word[31]` at its previous value.
- R3: A reset acknowledged from any source other than the external pin clears `word[31]`. It sets only that source's bit: `word[29]` loss of lock, `word[28]` loss of clock, `word[27]` watchdog/debug, `word[26]` software.
- R4: When requests rise together, exactly one is acknowledged. The order is loss of clock, then loss of lock, then watchdog/debug, then software, then external pin.
- R5: Outside power-on reset, exactly one of `word[30:26]` is set at all times.
- R6: Once a reset has been acknowledged, further requests are ignored until every request line is low at the same time.
- R7: In the first clock cycle with all requests low after a reset (power-on included), the block captures the pins. The wake-up pin goes to `word[15]`, boot pin 0 to `word[2]`, and boot pin 1 to `word[1]`. Pin levels seen during the request are not used.
- R8: Between resets the captured pin bits do not follow pin changes.
- R9: All bits other than `word[31:26]`, `word[15]` and `word[2:1]` read 0.
- R10: A read strobe in one cycle gives `rd_valid` high in the next cycle, with `rd_data` equal to the word at the strobe edge. Without a strobe, `rd_valid` is low and `rd_data` keeps its last value. Power-on clears both.
- R11: The word changes only when a reset is acknowledged or when the pins are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| ext_req | input | 1 | External reset pin request |
| lol_req | input | 1 | PLL loss-of-lock request |
| loc_req | input | 1 | Loss-of-clock request |
| wdg_req | input | 1 | Watchdog or debug request |
| sw_req | input | 1 | Software reset request |
| wake_pin | input | 1 | Wake-up configuration strap |
| boot_pins | input | 2 | Boot configuration straps, index 0 is boot pin 0 |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 32 | Status word |

## Verification
The bench builds the block with its default parameters: five cause lines and two boot straps placed at bit positions 29 and 30. With these values every pairing in the priority order can be reached in a few cycles. The same is true of every step in the sticky power-on sequence and of strap capture at each position. A behavioural model in the bench follows each request edge, and the bench compares the read port against it on every clock. Directed phases add simultaneous requests, requests that overlap an active reset, and strap changes made during and between resets.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_BOOT  = 2;

  // cause vector layout: index 4 ext, 3 loss of lock, 2 loss of clock, 1 watchdog, 0 software
  localparam int IDX_SW  = 0;
  localparam int IDX_WDG = 1;
  localparam int IDX_LOC = 2;
  localparam int IDX_LOL = 3;
  localparam int IDX_EXT = 4;

  // position 0 is highest priority
  localparam int CAUSE_PRIO [NUM_CAUSE] = '{IDX_LOC, IDX_LOL, IDX_WDG, IDX_SW, IDX_EXT};

  // MSB-first field positions inside the status word
  localparam int POS_POR   = 0;
  localparam int POS_CAUSE = 1;
  localparam int POS_WAKE  = 16;
  localparam int POS_BOOT  = 29;

  function automatic int lsb_index(input int msb_first_pos);
    return WORD_W - 1 - msb_first_pos;
  endfunction
endpackage

// File: rtl/rcsr_arbiter.sv
module rcsr_arbiter
  import rcsr_pkg::*;
#(
  parameter int N = NUM_CAUSE
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any_req
);
  always_comb begin
    grant = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[CAUSE_PRIO[k]]) begin
        grant = '0;
        grant[CAUSE_PRIO[k]] = 1'b1;
      end
    end
  end

  assign any_req = |req;

  // R4: a loss-of-clock request always wins
  always_comb begin
    if (req[IDX_LOC]) a_r4_loc_wins: assert (grant[IDX_LOC]);
    a_r4_single_grant: assert ($onehot0(grant) && ((grant != '0) == any_req));
  end
endmodule

// File: rtl/rcsr_capture.sv
module rcsr_capture
  import rcsr_pkg::*;
#(
  parameter int N_CAUSE = NUM_CAUSE,
  parameter int N_BOOT  = NUM_BOOT,
  parameter int EXT_IX  = IDX_EXT
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic [N_CAUSE-1:0] grant,
  input  logic               any_req,
  input  logic               wake_pin,
  input  logic [N_BOOT-1:0]  boot_pins,
  output logic               por_flag,
  output logic [N_CAUSE-1:0] cause_flags,
  output logic               wake_q,
  output logic [N_BOOT-1:0]  boot_q
);
  localparam logic [N_CAUSE-1:0] EXT_MASK = N_CAUSE'(1) << EXT_IX;

  logic busy_q;
  logic ack;
  logic sample_now;

  assign ack        = !busy_q && any_req;
  assign sample_now = busy_q && !any_req;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      por_flag    <= 1'b1;
      cause_flags <= EXT_MASK;
      busy_q      <= 1'b1;
      wake_q      <= 1'b0;
      boot_q      <= '0;
    end else if (ack) begin
      busy_q      <= 1'b1;
      cause_flags <= grant;
      if (!grant[EXT_IX]) por_flag <= 1'b0;
    end else if (sample_now) begin
      busy_q <= 1'b0;
      wake_q <= wake_pin;
      boot_q <= boot_pins;
    end
  end

  a_r5_one_cause: assert property (@(posedge clk) disable iff (por_req)
    $countones(cause_flags) == 1);

  a_r2_ext_keeps_por: assert property (@(posedge clk) disable iff (por_req)
    ack && grant[EXT_IX] |=> por_flag == $past(por_flag) && cause_flags == EXT_MASK);

  a_r3_other_clears_por: assert property (@(posedge clk) disable iff (por_req)
    ack && !grant[EXT_IX] |=> !por_flag);

  a_r6_ignore_while_busy: assert property (@(posedge clk) disable iff (por_req)
    busy_q && any_req |=> $stable(cause_flags) && $stable(por_flag));

  a_r8_pins_hold: assert property (@(posedge clk) disable iff (por_req)
    !sample_now |=> $stable(wake_q) && $stable(boot_q));

  a_r11_quiet: assert property (@(posedge clk) disable iff (por_req)
    !ack && !sample_now |=> $stable(cause_flags) && $stable(por_flag));
endmodule

// File: rtl/rcsr_readport.sv
module rcsr_readport
  import rcsr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         por_req,
  input  logic         rd_en,
  input  logic [W-1:0] word_in,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_in;
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (por_req)
    rd_en |=> rd_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (por_req)
    !rd_en |=> !rd_valid && $stable(rd_data));
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rcsr_pkg::*;
#(
  parameter int N_BOOT = NUM_BOOT
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              ext_req,
  input  logic              lol_req,
  input  logic              loc_req,
  input  logic              wdg_req,
  input  logic              sw_req,
  input  logic              wake_pin,
  input  logic [N_BOOT-1:0] boot_pins,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CAUSE_HI = lsb_index(POS_CAUSE);
  localparam int CAUSE_LO = CAUSE_HI - NUM_CAUSE + 1;

  logic [NUM_CAUSE-1:0] req_vec;
  logic [NUM_CAUSE-1:0] grant;
  logic                 any_req;
  logic                 por_flag;
  logic [NUM_CAUSE-1:0] cause_flags;
  logic                 wake_q;
  logic [N_BOOT-1:0]    boot_q;
  logic [WORD_W-1:0]    word;

  always_comb begin
    req_vec          = '0;
    req_vec[IDX_EXT] = ext_req;
    req_vec[IDX_LOL] = lol_req;
    req_vec[IDX_LOC] = loc_req;
    req_vec[IDX_WDG] = wdg_req;
    req_vec[IDX_SW]  = sw_req;
  end

  rcsr_arbiter #(.N(NUM_CAUSE)) u_arb (
    .req     (req_vec),
    .grant   (grant),
    .any_req (any_req)
  );

  rcsr_capture #(.N_CAUSE(NUM_CAUSE), .N_BOOT(N_BOOT), .EXT_IX(IDX_EXT)) u_cap (
    .clk         (clk),
    .por_req     (por_req),
    .grant       (grant),
    .any_req     (any_req),
    .wake_pin    (wake_pin),
    .boot_pins   (boot_pins),
    .por_flag    (por_flag),
    .cause_flags (cause_flags),
    .wake_q      (wake_q),
    .boot_q      (boot_q)
  );

  always_comb begin
    word                          = '0;
    word[lsb_index(POS_POR)]      = por_flag;
    word[CAUSE_HI:CAUSE_LO]       = cause_flags;
    word[lsb_index(POS_WAKE)]     = wake_q;
    for (int i = 0; i < N_BOOT; i++) begin
      word[lsb_index(POS_BOOT + i)] = boot_q[i];
    end
  end

  rcsr_readport #(.W(WORD_W)) u_rd (
    .clk      (clk),
    .por_req  (por_req),
    .rd_en    (rd_en),
    .word_in  (word),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/rst_cause_status_tb.sv
module rst_cause_status_tb;
  logic        clk = 1'b0;
  logic        por_req = 1'b1;
  logic        ext_req = 1'b0, lol_req = 1'b0, loc_req = 1'b0, wdg_req = 1'b0, sw_req = 1'b0;
  logic        wake_pin = 1'b0;
  logic [1:0]  boot_pins = 2'b00;
  logic        rd_en = 1'b1;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit model_on = 0;
  bit finished = 0;

  localparam logic [31:0] USED = 32'hFC00_8006;

  always #2.5 clk = ~clk;

  rst_cause_status u_dut (
    .clk(clk), .por_req(por_req), .ext_req(ext_req), .lol_req(lol_req),
    .loc_req(loc_req), .wdg_req(wdg_req), .sw_req(sw_req),
    .wake_pin(wake_pin), .boot_pins(boot_pins), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // behavioural reference model
  bit m_por, m_ext, m_lol, m_loc, m_wdg, m_sw, m_busy, m_wake, m_b0, m_b1;
  bit m_rdv;
  logic [31:0] m_rdd;

  function automatic logic [31:0] m_word();
    logic [31:0] w = 32'h0;
    w[31] = m_por; w[30] = m_ext; w[29] = m_lol; w[28] = m_loc;
    w[27] = m_wdg; w[26] = m_sw;  w[15] = m_wake; w[2] = m_b0; w[1] = m_b1;
    return w;
  endfunction

  always @(posedge clk) begin
    if (por_req) begin
      m_por = 1; m_ext = 1; m_lol = 0; m_loc = 0; m_wdg = 0; m_sw = 0;
      m_busy = 1; m_wake = 0; m_b0 = 0; m_b1 = 0; m_rdv = 0; m_rdd = 32'h0;
    end else begin
      m_rdv = rd_en;
      if (rd_en) m_rdd = m_word();
      if (!m_busy && (ext_req || lol_req || loc_req || wdg_req || sw_req)) begin
        m_busy = 1;
        {m_ext, m_lol, m_loc, m_wdg, m_sw} = 5'b0;
        if (loc_req)      begin m_loc = 1; m_por = 0; end
        else if (lol_req) begin m_lol = 1; m_por = 0; end
        else if (wdg_req) begin m_wdg = 1; m_por = 0; end
        else if (sw_req)  begin m_sw  = 1; m_por = 0; end
        else              m_ext = 1;
      end else if (m_busy && !(ext_req || lol_req || loc_req || wdg_req || sw_req)) begin
        m_busy = 0; m_wake = wake_pin; m_b0 = boot_pins[0]; m_b1 = boot_pins[1];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every clock, before new inputs are driven
  always @(negedge clk) begin
    if (model_on && !por_req) begin
      chk("R10 rd_valid", {31'h0, rd_valid}, {31'h0, m_rdv});
      chk("R5 cause bits", {26'h0, rd_data[31:26]}, {26'h0, m_rdd[31:26]});
      chk("R7 strap bits", rd_data & 32'h0000_8006, m_rdd & 32'h0000_8006);
      chk("R9 unused bits", rd_data & ~USED, 32'h0);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] r, input int hold);
    @(negedge clk);
    {ext_req, lol_req, loc_req, wdg_req, sw_req} = r;
    idle(hold);
    {ext_req, lol_req, loc_req, wdg_req, sw_req} = 5'b0;
    idle(3);
  endtask

  initial begin
    wake_pin = 1'b1; boot_pins = 2'b10;
    idle(3);
    chk("R1 during por", rd_data, 32'h0);
    por_req = 1'b0;
    model_on = 1;
    idle(3);
    chk("R1 R7 cold start", rd_data, 32'hC000_8002);

    wake_pin = 1'b0; boot_pins = 2'b01;
    idle(4);
    chk("R8 R11 pins hold", rd_data, 32'hC000_8002);

    do_reset(5'b10000, 2);
    chk("R2 ext keeps por", rd_data, 32'hC000_0004);

    wake_pin = 1'b1; boot_pins = 2'b11;
    do_reset(5'b00010, 3);
    chk("R3 watchdog", rd_data, 32'h0800_8006);

    do_reset(5'b10001, 1);
    chk("R4 sw over ext", rd_data, 32'h0400_8006);

    do_reset(5'b11001, 2);
    chk("R4 lol over sw ext", rd_data, 32'h2000_8006);

    do_reset(5'b01110, 2);
    chk("R4 loc over lol wdg", rd_data, 32'h1000_8006);

    do_reset(5'b10000, 2);
    chk("R2 ext after other", rd_data, 32'h4000_8006);

    // R6: loss of clock arrives while a software reset is held
    @(negedge clk); sw_req = 1'b1;
    idle(2); loc_req = 1'b1;
    idle(2); sw_req = 1'b0;
    idle(1); loc_req = 1'b0;
    idle(3);
    chk("R6 overlap ignored", rd_data, 32'h0400_8006);

    // R7: straps changing during the request, capture uses level at release
    @(negedge clk); lol_req = 1'b1; wake_pin = 1'b1; boot_pins = 2'b11;
    idle(2); wake_pin = 1'b0; boot_pins = 2'b01;
    lol_req = 1'b0;
    idle(3);
    chk("R7 capture at release", rd_data, 32'h2000_0004);

    // R10: strobe off while a reset changes the word
    @(negedge clk); rd_en = 1'b0; wdg_req = 1'b1;
    idle(1); wdg_req = 1'b0;
    idle(3);
    chk("R10 data held", rd_data, 32'h2000_0004);
    chk("R10 valid low", {31'h0, rd_valid}, 32'h0);
    rd_en = 1'b1;
    idle(1);
    chk("R10 read after strobe", rd_data, 32'h0800_0004);

    // alternating strobe pattern with random-ish resets, model-checked
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd_en = i[0] | i[2];
      {ext_req, lol_req, loc_req, wdg_req, sw_req} = ((i % 7) == 3) ? 5'(i * 13) : 5'b0;
      wake_pin = i[3]; boot_pins = 2'(i >> 1);
    end
    {ext_req, lol_req, loc_req, wdg_req, sw_req} = 5'b0;
    rd_en = 1'b1;

    // second power-on restores the cold-start pattern
    @(negedge clk); por_req = 1'b1; wake_pin = 1'b0; boot_pins = 2'b01;
    idle(2); por_req = 1'b0;
    idle(3);
    chk("R1 second power-on", rd_data, 32'hC000_0004);
    chk("R9 unused zero", rd_data & ~USED, 32'h0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule